// File: doc/BRIEF.md
# Byte Lane Realigner

This block sits in the data path of a memory-to-memory copy engine whose bus is 32 or 64 bits wide. A copy may begin reading at any byte offset within a bus word and may begin writing at any other byte offset. The realigner takes the read beats and moves each byte to the lane it must occupy on the write side. Bytes that cross a word boundary are kept in a one-word carry register until the next output word. Each output beat comes with byte strobes, and the final beat of a copy is marked.

A copy starts with a command that gives the source lane offset, the destination lane offset and the total byte count, which must be at least one. The engine then takes `ceil((src_off+bytes)/NB)` input words and produces `ceil((dst_off+bytes)/NB)` output words, where NB is the number of byte lanes. When the output needs one word more than the input supplies, the engine emits one extra word from the carry register. When the source offset is larger than the destination offset, the first input word only loads the carry register. Input and output both use valid/ready handshakes. While one copy is in progress, no new command is accepted.

Top module: `byte_realigner`

## Requirements
- R1: After reset and whenever no copy is in progress, cmd_ready is 1, and in_ready and out_valid are both 0.
- R2: out_strb has DATA_W/8 bits. Bit n qualifies byte lane n, which is out_data[8n+7:8n]. Realignment works at the granularity of single bytes.
- R3: Byte j of the copy (0 <= j < bytes) is taken from input word (src_off+j)/NB, lane (src_off+j)%NB. It appears on output word (dst_off+j)/NB, lane (dst_off+j)%NB. This holds for every pair of offsets.
- R4: A copy consumes exactly ceil((src_off+bytes)/NB) input words and produces exactly ceil((dst_off+bytes)/NB) output words.
- R5: On the first output word, only strobe lanes >= dst_off are set. On the last output word, only lanes <= (dst_off+bytes-1)%NB are set. Every word in between has all strobes set. A word that is both first and last meets both limits.
- R6: The output word count can exceed (input words - (1 if src_off > dst_off else 0)). When it does, exactly one extra word is emitted from the carry register after the last input word has been taken.
- R7: out_last is 1 on the final output word of a copy and 0 on every other output word.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_strb and out_last hold their values. No input word is consumed unless it also completes an output word or only loads the carry register. No byte is lost.
- R9: One cycle after the final output word is taken, cmd_ready is 1 again. The next copy is unaffected by bytes left over from the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Copy command present |
| cmd_ready | output | 1 | Engine idle, command accepted |
| cmd_src_off | input | OFF_W | Byte lane of the first source byte |
| cmd_dst_off | input | OFF_W | Byte lane of the first destination byte |
| cmd_bytes | input | LEN_W | Total bytes in the copy (>= 1) |
| in_valid | input | 1 | Read word present |
| in_ready | output | 1 | Read word taken |
| in_data | input | DATA_W | Read word |
| out_valid | output | 1 | Write word present |
| out_ready | input | 1 | Write word taken |
| out_data | output | DATA_W | Realigned write word |
| out_strb | output | DATA_W/8 | Byte strobes for out_data |
| out_last | output | 1 | Final write word of the copy |

## Verification
Two things often coincide in one cycle: the first-word strobe limit and the last-word strobe limit, and taking an input word and emitting an output word. Short copies of one to NB bytes at every pair of offsets make the first and last words the same word, so the two strobe masks must be combined. Other copies end exactly on a lane boundary, or just past one, so that the final output word is either built from the last input word or flushed from the carry register. The bench model predicts the strobe mask of every word, and it predicts the number of words that arrive after the input is exhausted. Random gaps on out_ready make the engine stall in the same cycle that an input word is offered, so a lost or duplicated byte shows up as a data mismatch.

// File: rtl/realign_pkg.sv
package realign_pkg;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_e;

   // Data widths for which lane realignment is offered.
   function automatic bit lane_width_ok(input int w);
      return (w == 32) || (w == 64);
   endfunction

endpackage

// File: rtl/realign_ctl.sv
module realign_ctl
   import realign_pkg::*;
#(
   parameter int NB    = 4,
   parameter int OFF_W = 2,
   parameter int LEN_W = 16,
   parameter int CNT_W = LEN_W + 2 - OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [OFF_W-1:0] cmd_src_off,
   input  logic [OFF_W-1:0] cmd_dst_off,
   input  logic [LEN_W-1:0] cmd_bytes,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             out_ready,
   output logic             out_valid,
   output logic             out_last,
   output logic             first_beat,
   output logic             flush,
   output logic             carry_we,
   output logic [OFF_W-1:0] shift,
   output logic [OFF_W-1:0] dst_lane,
   output logic [OFF_W-1:0] end_lane
);

   phase_e           phase;
   logic             skip_q;
   logic             first_q;
   logic [CNT_W-1:0] in_left;
   logic [CNT_W-1:0] out_left;
   logic [OFF_W-1:0] shift_q;
   logic [OFF_W-1:0] dst_q;
   logic [OFF_W-1:0] end_q;
   logic [LEN_W+1:0] in_sum;
   logic [LEN_W+1:0] out_sum;
   logic             have_in;
   logic             cmd_hs;
   logic             in_hs;
   logic             out_hs;

   assign in_sum  = {2'b00, cmd_bytes} + (LEN_W+2)'(cmd_src_off) + (LEN_W+2)'(NB - 1);
   assign out_sum = {2'b00, cmd_bytes} + (LEN_W+2)'(cmd_dst_off) + (LEN_W+2)'(NB - 1);

   assign have_in   = (in_left != '0);
   assign cmd_ready = (phase == PH_IDLE);
   assign out_valid = (phase == PH_RUN) && (have_in ? (in_valid && !skip_q) : 1'b1);
   assign in_ready  = (phase == PH_RUN) && have_in && (skip_q || out_ready);
   assign out_last  = (out_left == CNT_W'(1));
   assign flush     = (phase == PH_RUN) && !have_in;

   assign cmd_hs   = cmd_valid && cmd_ready;
   assign in_hs    = in_valid && in_ready;
   assign out_hs   = out_valid && out_ready;
   assign carry_we = in_hs;

   assign first_beat = first_q;
   assign shift      = shift_q;
   assign dst_lane   = dst_q;
   assign end_lane   = end_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         skip_q   <= 1'b0;
         first_q  <= 1'b0;
         in_left  <= '0;
         out_left <= '0;
         shift_q  <= '0;
         dst_q    <= '0;
         end_q    <= '0;
      end else if (cmd_hs) begin
         phase    <= PH_RUN;
         skip_q   <= (cmd_dst_off < cmd_src_off);
         first_q  <= 1'b1;
         in_left  <= in_sum[LEN_W+1:OFF_W];
         out_left <= out_sum[LEN_W+1:OFF_W];
         shift_q  <= cmd_dst_off - cmd_src_off;
         dst_q    <= cmd_dst_off;
         end_q    <= cmd_dst_off + cmd_bytes[OFF_W-1:0] - OFF_W'(1);
      end else begin
         if (in_hs) begin
            in_left <= in_left - CNT_W'(1);
            skip_q  <= 1'b0;
         end
         if (out_hs) begin
            out_left <= out_left - CNT_W'(1);
            first_q  <= 1'b0;
            if (out_left == CNT_W'(1)) phase <= PH_IDLE;
         end
      end
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (!in_ready && !out_valid));

   // R9
   last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> cmd_ready);

   // R6
   flush_after_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && out_valid) |-> !in_ready);

endmodule

// File: rtl/realign_shift.sv
module realign_shift #(
   parameter int NB    = 4,
   parameter int OFF_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [8*NB-1:0]  in_data,
   input  logic             carry_we,
   input  logic             flush,
   input  logic [OFF_W-1:0] shift,
   output logic [8*NB-1:0]  out_data
);

   logic [8*NB-1:0] rot;
   logic [8*NB-1:0] carry_q;

   for (genvar l = 0; l < NB; l++) begin : g_lane
      logic [OFF_W-1:0] pick;
      logic             from_carry;
      assign pick       = OFF_W'(l) - shift;
      assign rot[8*l +: 8] = in_data[{pick, 3'b000} +: 8];
      assign from_carry = (OFF_W'(l) < shift);
      assign out_data[8*l +: 8] = from_carry ? carry_q[8*l +: 8] :
                                  (flush ? 8'h00 : rot[8*l +: 8]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        carry_q <= '0;
      else if (carry_we) carry_q <= rot;
   end

   // R8
   carry_only_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_we |=> $stable(carry_q));

endmodule

// File: rtl/realign_strobe.sv
module realign_strobe #(
   parameter int NB    = 4,
   parameter int OFF_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             first_beat,
   input  logic             last_beat,
   input  logic [OFF_W-1:0] dst_lane,
   input  logic [OFF_W-1:0] end_lane,
   output logic [NB-1:0]    strb
);

   for (genvar l = 0; l < NB; l++) begin : g_strb
      assign strb[l] = (!first_beat || (OFF_W'(l) >= dst_lane)) &&
                       (!last_beat  || (OFF_W'(l) <= end_lane));
   end

   // R5
   strobe_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (strb != '0));

endmodule

// File: rtl/byte_realigner.sv
module byte_realigner
   import realign_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16,
   localparam int NB    = DATA_W / 8,
   localparam int OFF_W = $clog2(NB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [OFF_W-1:0]  cmd_src_off,
   input  logic [OFF_W-1:0]  cmd_dst_off,
   input  logic [LEN_W-1:0]  cmd_bytes,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic [NB-1:0]     out_strb,
   output logic              out_last
);

   localparam int CNT_W = LEN_W + 2 - OFF_W;

   if (!lane_width_ok(DATA_W)) begin : g_bad_width
      $error("byte_realigner: DATA_W must be 32 or 64");
   end
   if (LEN_W <= OFF_W) begin : g_bad_len
      $error("byte_realigner: LEN_W must exceed the lane offset width");
   end

   logic             first_beat;
   logic             flush;
   logic             carry_we;
   logic [OFF_W-1:0] shift;
   logic [OFF_W-1:0] dst_lane;
   logic [OFF_W-1:0] end_lane;

   realign_ctl #(.NB(NB), .OFF_W(OFF_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .cmd_src_off(cmd_src_off),
      .cmd_dst_off(cmd_dst_off),
      .cmd_bytes  (cmd_bytes),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .out_ready  (out_ready),
      .out_valid  (out_valid),
      .out_last   (out_last),
      .first_beat (first_beat),
      .flush      (flush),
      .carry_we   (carry_we),
      .shift      (shift),
      .dst_lane   (dst_lane),
      .end_lane   (end_lane)
   );

   realign_shift #(.NB(NB), .OFF_W(OFF_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_data (in_data),
      .carry_we(carry_we),
      .flush   (flush),
      .shift   (shift),
      .out_data(out_data)
   );

   realign_strobe #(.NB(NB), .OFF_W(OFF_W)) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (out_valid),
      .first_beat(first_beat),
      .last_beat (out_last),
      .dst_lane  (dst_lane),
      .end_lane  (end_lane),
      .strb      (out_strb)
   );

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_strb) && $stable(out_last)));

   // R7
   last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !out_last) |=> !cmd_ready);

endmodule

// File: tb/sim_byte_realigner.sv
module sim_byte_realigner;

   localparam int DATA_W = 32;
   localparam int LEN_W  = 16;
   localparam int NB     = DATA_W / 8;
   localparam int OFF_W  = $clog2(NB);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic              cmd_ready;
   logic [OFF_W-1:0]  cmd_src_off = '0;
   logic [OFF_W-1:0]  cmd_dst_off = '0;
   logic [LEN_W-1:0]  cmd_bytes = '0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [DATA_W-1:0] in_data = '0;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [DATA_W-1:0] out_data;
   logic [NB-1:0]     out_strb;
   logic              out_last;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;
   bit timed_out = 1'b0;

   always #5 clk = ~clk;

   byte_realigner #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_src_off(cmd_src_off), .cmd_dst_off(cmd_dst_off), .cmd_bytes(cmd_bytes),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_strb(out_strb), .out_last(out_last)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // mode 0: always ready/valid; 1: random gaps on both sides
   task automatic run_copy(input int src, input int dst, input int nbytes, input int mode);
      byte unsigned     bq[$];
      logic [DATA_W-1:0] ibeat[$];
      logic [DATA_W-1:0] edata[$];
      logic [NB-1:0]     estrb[$];
      int n_in, n_out, skip, in_ptr, out_cnt, flush_seen;
      bit done, hs_cmd, hs_in, hs_out;
      if (timed_out) return;
      n_in  = (src + nbytes + NB - 1) / NB;
      n_out = (dst + nbytes + NB - 1) / NB;
      skip  = (dst < src) ? 1 : 0;
      for (int j = 0; j < nbytes; j++) bq.push_back(byte'($urandom));
      for (int i = 0; i < n_in; i++) begin
         logic [DATA_W-1:0] w;
         for (int l = 0; l < NB; l++) begin
            int j = i*NB + l - src;
            w[8*l +: 8] = (j >= 0 && j < nbytes) ? bq[j] : 8'($urandom);
         end
         ibeat.push_back(w);
      end
      for (int k = 0; k < n_out; k++) begin
         logic [DATA_W-1:0] w;
         logic [NB-1:0]     s;
         for (int l = 0; l < NB; l++) begin
            int j = k*NB + l - dst;
            s[l] = (j >= 0 && j < nbytes);
            w[8*l +: 8] = s[l] ? bq[j] : 8'h00;
         end
         edata.push_back(w);
         estrb.push_back(s);
      end
      in_ptr = 0; out_cnt = 0; flush_seen = 0; done = 1'b0;
      cmd_src_off = OFF_W'(src);
      cmd_dst_off = OFF_W'(dst);
      cmd_bytes   = LEN_W'(nbytes);
      cmd_valid   = 1'b1;
      in_valid    = 1'b1;
      in_data     = ibeat[0];
      out_ready   = (mode == 0) ? 1'b1 : 1'($urandom % 2);
      while (!done) begin
         @(negedge clk);
         cycles++;
         if (cycles > 150000) begin
            timed_out = 1'b1;
            check(1'b0, "watchdog", cycles, 0);
            break;
         end
         // R1 idle quiet
         if (cmd_ready) check(!in_ready && !out_valid, "R1 idle traffic", {in_ready, out_valid}, 0);
         hs_cmd = cmd_valid && cmd_ready;
         hs_in  = in_valid && in_ready;
         hs_out = out_valid && out_ready;
         if (hs_out) begin
            if (out_cnt >= n_out) begin
               check(1'b0, "R4 extra output word", out_cnt + 1, n_out);
            end else begin
               check(out_strb == estrb[out_cnt], "R5 strobes", out_strb, estrb[out_cnt]);
               check(out_last == (out_cnt == n_out - 1), "R7 last flag", out_last, (out_cnt == n_out - 1));
               for (int l = 0; l < NB; l++)
                  if (estrb[out_cnt][l])
                     check(out_data[8*l +: 8] == edata[out_cnt][8*l +: 8],
                           "R3/R2 lane byte", out_data[8*l +: 8], edata[out_cnt][8*l +: 8]);
               if (in_ptr == n_in) flush_seen++;
               if (out_cnt == n_out - 1) done = 1'b1;
            end
            out_cnt++;
         end
         if (hs_in) in_ptr++;
         @(posedge clk);
         #1;
         if (hs_cmd) cmd_valid = 1'b0;
         if (in_ptr < n_in) begin
            if (!(in_valid && !hs_in)) begin
               in_valid = (mode == 0) ? 1'b1 : ($urandom % 4 != 0);
               in_data  = ibeat[in_ptr];
            end
         end else begin
            in_valid = 1'b0;
         end
         out_ready = (mode == 0) ? 1'b1 : 1'($urandom % 2);
      end
      in_valid  = 1'b0;
      out_ready = 1'b0;
      if (timed_out) return;
      @(negedge clk);
      cycles++;
      check(cmd_ready == 1'b1, "R9 ready after last", cmd_ready, 1);
      check(!out_valid, "R4 no word after last", out_valid, 0);
      check(in_ptr == n_in, "R4 input words taken", in_ptr, n_in);
      check(out_cnt == n_out, "R4 output words", out_cnt, n_out);
      check(flush_seen == n_out - n_in + skip, "R6 flush words", flush_seen, n_out - n_in + skip);
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(cmd_ready == 1'b1, "R1 reset cmd_ready", cmd_ready, 1);
      check(!in_ready && !out_valid, "R1 reset quiet", {in_ready, out_valid}, 0);
      @(posedge clk);
      #1;
      // every pair of offsets, short copies where first word is also last (R5)
      for (int s = 0; s < NB; s++)
         for (int d = 0; d < NB; d++)
            for (int n = 1; n <= NB; n++)
               run_copy(s, d, n, 0);
      // every pair, longer copies, steady and with stalls (R3, R6, R8)
      for (int s = 0; s < NB; s++)
         for (int d = 0; d < NB; d++) begin
            run_copy(s, d, 4*NB - s, 0);
            run_copy(s, d, 4*NB - d + 1, 1);
            run_copy(s, d, 5 + $urandom % 40, 1);
         end
      // back-to-back copies: carry from one copy must not leak (R9)
      run_copy(3, 0, 9, 1);
      run_copy(0, 3, 9, 1);
      run_copy(1, 2, 1, 0);
      run_copy(0, 0, 200, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule